// File: doc/BRIEF.md
# Configurable SPI Bus Master

This block is a single-line SPI bus master. A host hands it one command through a valid/ready handshake. The command carries a data word, a size select of 8 or 16 bits, a mode flag and a set of configuration inputs. The configuration covers the chip-select active level, the chip-select setup and hold delays, the clock idle level, the sampling phase and a clock divider.

After accepting a command, the block does the following:
- It drives the chip-select line to its active level.
- It waits out the setup delay.
- It produces a burst of SCLK cycles. Each cycle shifts one bit out on MOSI, most significant bit first, and captures one bit from MISO.
- It waits out the hold delay and releases chip-select.
- It pulses `done`.

In write-and-read mode the captured word is presented on `rd_data`. In write-only mode the captured bits are discarded. To read a reply without sending anything meaningful, the host passes dummy data, for example all ones, in write-and-read mode. The block sends that data exactly as given.

Back-pressure works as follows:
- `cmd_ready` is high only while the block is idle.
- A command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high.
- `cmd_valid` has no effect while `cmd_ready` is low.
- The result side has no back-pressure. `done` is a one-cycle pulse, and `rd_data` holds until the next write-and-read result.

Top module: `spi_cmd_master`

## Requirements
- R1: Out of reset and whenever no transfer is in progress, `cmd_ready` is 1 and `sclk` rests at the idle level latched with the last accepted command. After reset that level is 0, `cs` is 1, `done` is 0 and `rd_data` is 0.
- R2: A command is accepted only when `cmd_valid` and `cmd_ready` are both high. The command and all `cfg_*` inputs are sampled at acceptance only. `cmd_valid` while busy, and changes to `cfg_*` during a transfer, have no effect.
- R3: Every SCLK half period lasts `cfg_div`+1 system-clock cycles.
- R4: The first SCLK edge occurs `cfg_setup`+`cfg_div`+2 cycles after `cs` goes active. This is `cfg_setup`+1 cycles of setup delay plus one half period.
- R5: `cs` returns to its inactive level exactly `cfg_hold`+1 cycles after the last SCLK edge.
- R6: A transfer makes 2·N SCLK edges, with N = 16 when `cmd_wide`=1 and N = 8 when `cmd_wide`=0. SCLK ends at its idle level.
- R7: Bits leave MSB first. A 16-bit word sends `cmd_data[15:0]`; an 8-bit word sends `cmd_data[7:0]`. Any value, including all-ones dummy data, is sent unchanged.
- R8: With `cfg_cpha`=0, MISO is captured on each leading edge (the edge leaving the idle level) and MOSI changes on trailing edges. With `cfg_cpha`=1, MOSI changes on leading edges after the first and MISO is captured on trailing edges. The MSB is on MOSI from the moment `cs` goes active.
- R9: With `cfg_cs_act_hi`=1, `cs` is active high; with 0 it is active low. Between transfers `cs` sits at the opposite of the last accepted level.
- R10: `done` is a one-cycle pulse in the first cycle in which `cs` is inactive again, and `cmd_ready` is 1 in that cycle.
- R11: With `cmd_rw`=1, `rd_data` takes the captured bits in the `done` cycle, first captured bit in the MSB of the word. An 8-bit word lands in `rd_data[7:0]` with the upper bits zero. With `cmd_rw`=0, `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_data | input | WORD_W | Word to transmit |
| cmd_wide | input | 1 | 1: 16-bit word, 0: 8-bit word |
| cmd_rw | input | 1 | 1: write-and-read, 0: write-only |
| cfg_cs_act_hi | input | 1 | Chip-select active level |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | Sampling phase |
| cfg_div | input | DIV_W | Half period minus one, in system cycles |
| cfg_setup | input | DLY_W | Setup delay minus one, in system cycles |
| cfg_hold | input | DLY_W | Hold delay minus one, in system cycles |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 1 | Chip select |
| done | output | 1 | Transfer complete pulse |
| rd_data | output | WORD_W | Last received word |

## Verification
The bound checker watches several rules on every cycle:
- SCLK stays at its idle level whenever chip-select is inactive.
- The block is never ready while selected.
- No SCLK edge comes before the setup delay has run out.
- The hold delay is honoured before release.
- Each selection carries exactly 2·N edges.
- `done` is a single pulse.
- `rd_data` moves only on a write-and-read completion.

The bench's scenarios show what needs a model of the slave:
- the exact half-period length;
- the MSB-first bit order on MOSI and the capture phase for all four clock modes;
- the received word value;
- that a command offered while busy, or configuration changed mid-transfer, leaves the burst and the idle state unaffected.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_HOLD  = 2'd3
  } ctl_state_e;

  // Per-transfer settings captured when a command is accepted
  typedef struct packed {
    logic act_hi;
    logic cpha;
    logic wide;
    logic rw;
  } xfer_mode_t;

endpackage

// File: rtl/spi_rate_gen.sv
// Produces one tick per SCLK half period while run is high
module spi_rate_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_delay_timer.sv
// Down counter shared by the setup and hold phases; value v lasts v+1 cycles
module spi_delay_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             expired
);
  logic [DLY_W-1:0] cnt_q;

  assign expired = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load)     cnt_q <= load_val;
    else if (!expired) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/spi_bit_engine.sv
// SCLK toggling plus transmit and receive shift registers, indexed by edge count
module spi_bit_engine #(
  parameter int WORD_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              load_wide,
  input  logic              load_cpol,
  input  logic              run_wide,
  input  logic              run_cpha,
  input  logic              tick,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              final_edge,
  output logic [WORD_W-1:0] rx_word
);
  localparam int EDGE_W = $clog2(2 * WORD_W + 1);
  localparam logic [EDGE_W-1:0] LAST_LONG  = EDGE_W'(2 * WORD_W - 1);
  localparam logic [EDGE_W-1:0] LAST_SHORT = EDGE_W'(2 * SHORT_W - 1);

  logic [WORD_W-1:0] tx_q, rx_q, short_img;
  logic [EDGE_W-1:0] edge_q, last_idx;
  logic              sclk_q, capture, launch;

  // A short word is left-aligned so the shared MSB tap serves both sizes
  generate
    if (SHORT_W < WORD_W) begin : g_pad
      assign short_img = {load_word[SHORT_W-1:0], {(WORD_W - SHORT_W){1'b0}}};
    end else begin : g_nopad
      assign short_img = load_word;
    end
  endgenerate

  assign last_idx   = run_wide ? LAST_LONG : LAST_SHORT;
  // Even edge index = leading edge. Capture on leading when cpha=0, else on trailing
  assign capture    = (edge_q[0] == run_cpha);
  assign launch     = !capture && (edge_q != '0);
  assign final_edge = tick && (edge_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      edge_q <= '0;
      sclk_q <= 1'b0;
    end else if (load) begin
      tx_q   <= load_wide ? load_word : short_img;
      rx_q   <= '0;
      edge_q <= '0;
      sclk_q <= load_cpol;
    end else if (tick) begin
      sclk_q <= ~sclk_q;
      edge_q <= edge_q + 1'b1;
      if (capture) rx_q <= {rx_q[WORD_W-2:0], miso};
      if (launch)  tx_q <= {tx_q[WORD_W-2:0], 1'b0};
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_q[WORD_W-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int SHORT_W = 8,
  parameter int DIV_W   = 8,
  parameter int DLY_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              cmd_wide,
  input  logic              cmd_rw,
  input  logic              cfg_cs_act_hi,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [DLY_W-1:0]  cfg_setup,
  input  logic [DLY_W-1:0]  cfg_hold,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs,
  output logic              done,
  output logic [WORD_W-1:0] rd_data
);
  ctl_state_e        st_q, st_d;
  xfer_mode_t        mode_q;
  logic [DIV_W-1:0]  div_q;
  logic [DLY_W-1:0]  hold_q;
  logic [WORD_W-1:0] rx_word, rd_q;
  logic              cs_q, done_q;
  logic              accept, tick, final_edge, expired, finish;

  assign cmd_ready = (st_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign finish    = (st_q == ST_HOLD) && expired;

  spi_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st_q == ST_SHIFT),
    .div  (div_q),
    .tick (tick)
  );

  spi_delay_timer #(.DLY_W(DLY_W)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept || final_edge),
    .load_val(accept ? cfg_setup : hold_q),
    .expired (expired)
  );

  spi_bit_engine #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_word (cmd_data),
    .load_wide (cmd_wide),
    .load_cpol (cfg_cpol),
    .run_wide  (mode_q.wide),
    .run_cpha  (mode_q.cpha),
    .tick      (tick),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .final_edge(final_edge),
    .rx_word   (rx_word)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept)     st_d = ST_SETUP;
      ST_SETUP: if (expired)    st_d = ST_SHIFT;
      ST_SHIFT: if (final_edge) st_d = ST_HOLD;
      ST_HOLD:  if (expired)    st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= '0;
      div_q  <= '0;
      hold_q <= '0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      if (accept) begin
        mode_q <= '{act_hi: cfg_cs_act_hi, cpha: cfg_cpha, wide: cmd_wide, rw: cmd_rw};
        div_q  <= cfg_div;
        hold_q <= cfg_hold;
        cs_q   <= cfg_cs_act_hi;
      end else if (finish) begin
        cs_q <= ~mode_q.act_hi;
      end
      if (finish && mode_q.rw) rd_q <= rx_word;
    end
  end

  assign cs      = cs_q;
  assign done    = done_q;
  assign rd_data = rd_q;
endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk #(
  parameter int WORD_W  = 16,
  parameter int SHORT_W = 8,
  parameter int DIV_W   = 8,
  parameter int DLY_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_wide,
  input logic              cmd_rw,
  input logic              cfg_cs_act_hi,
  input logic              cfg_cpol,
  input logic [DLY_W-1:0]  cfg_setup,
  input logic [DLY_W-1:0]  cfg_hold,
  input logic              sclk,
  input logic              cs,
  input logic              done,
  input logic [WORD_W-1:0] rd_data
);
  localparam int CW = ((DLY_W > DIV_W) ? DLY_W : DIV_W) + 2;
  localparam int EW = $clog2(2 * WORD_W + 1) + 1;
  localparam int QW = DLY_W + 1;

  logic             act_hi_c, cpol_c, wide_c, rw_c;
  logic [DLY_W-1:0] setup_c, hold_c;
  logic             prev_sclk, prev_on, cs_on, tog;
  logic [CW-1:0]    act_cnt;
  logic [QW-1:0]    quiet;
  logic [EW-1:0]    edg;

  assign cs_on = (cs == act_hi_c);
  assign tog   = (sclk != prev_sclk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_hi_c <= 1'b0; cpol_c <= 1'b0; wide_c <= 1'b0; rw_c <= 1'b0;
      setup_c <= '0; hold_c <= '0;
      prev_sclk <= 1'b0; prev_on <= 1'b0;
      act_cnt <= '0; quiet <= '0; edg <= '0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        act_hi_c <= cfg_cs_act_hi; cpol_c <= cfg_cpol;
        wide_c <= cmd_wide; rw_c <= cmd_rw;
        setup_c <= cfg_setup; hold_c <= cfg_hold;
      end
      prev_sclk <= sclk;
      prev_on   <= cs_on;
      act_cnt   <= !cs_on ? '0 : ((act_cnt == '1) ? act_cnt : act_cnt + 1'b1);
      quiet     <= tog ? '0 : ((quiet == '1) ? quiet : quiet + 1'b1);
      edg       <= (cs_on && prev_on) ? edg + EW'(tog) : '0;
    end
  end

  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_on |-> sclk == cpol_c);
  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !cs_on);
  assert_busy_no_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_on && prev_on) |-> !cmd_ready);
  assert_setup_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_on && prev_on && tog) |-> act_cnt > CW'(setup_c));
  assert_hold_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_on) |-> quiet >= QW'(hold_c));
  assert_edge_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_on) |-> edg == (wide_c ? EW'(2 * WORD_W) : EW'(2 * SHORT_W)));
  assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && !cs_on));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_rd_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_data));
  assert_rd_wo_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rw_c) |-> $stable(rd_data));
endmodule

bind spi_cmd_master spi_cmd_master_chk #(
  .WORD_W(WORD_W), .SHORT_W(SHORT_W), .DIV_W(DIV_W), .DLY_W(DLY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_wide(cmd_wide), .cmd_rw(cmd_rw), .cfg_cs_act_hi(cfg_cs_act_hi),
  .cfg_cpol(cfg_cpol), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
  .sclk(sclk), .cs(cs), .done(done), .rd_data(rd_data)
);

// File: tb/sim_spi_cmd_master.sv
module sim_spi_cmd_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_data = '0;
  logic        cmd_wide = 1'b0, cmd_rw = 1'b0;
  logic        cfg_cs_act_hi = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [7:0]  cfg_div = '0, cfg_setup = '0, cfg_hold = '0;
  logic        sclk, mosi, cs, done;
  logic        miso = 1'b0;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] exp_rd = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_cmd_master u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_wide(cmd_wide), .cmd_rw(cmd_rw),
    .cfg_cs_act_hi(cfg_cs_act_hi), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_div(cfg_div), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs(cs), .done(done),
    .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    finish_sim();
  end

  // One complete transfer with a slave model on MISO and a monitor on MOSI/SCLK/CS
  task automatic xfer(input logic [15:0] data, input logic [15:0] reply,
                      input bit wide, input bit rw, input bit act_hi,
                      input bit cpol, input bit cpha, input int div,
                      input int setup, input int hold, input bit poke);
    int n = wide ? 16 : 8;
    int cyc = 0, first_at = -1, last_at = 0, edges = 0, caps = 0, bad_half = 0;
    logic [15:0] got = '0;
    logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
    logic prev;
    bit leading, capture;

    @(negedge clk);
    cmd_data = data; cmd_wide = wide; cmd_rw = rw;
    cfg_cs_act_hi = act_hi; cfg_cpol = cpol; cfg_cpha = cpha;
    cfg_div = 8'(div); cfg_setup = 8'(setup); cfg_hold = 8'(hold);
    miso = reply[n-1];
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cs == act_hi, "R9 cs active level", cs, act_hi);
    chk(cmd_ready == 1'b0, "R2 busy after accept", cmd_ready, 0);
    chk(mosi == data[n-1], "R8 MSB on mosi at select", mosi, data[n-1]);
    // R2: configuration changes mid-transfer must not matter
    cmd_wide = ~wide; cmd_rw = ~rw; cfg_cs_act_hi = ~act_hi;
    cfg_cpol = ~cpol; cfg_cpha = ~cpha;
    cfg_div = 8'(div + 3); cfg_setup = 8'(setup + 5); cfg_hold = 8'(hold + 2);
    prev = sclk;
    forever begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin cmd_valid = 1'b1; cmd_data = ~data; end
      if (poke && cyc == 6) cmd_valid = 1'b0;
      if (cs != act_hi) break;
      if (done) chk(0, "R10 done while selected", 1, 0);
      if (sclk != prev) begin
        if (edges == 0) first_at = cyc;
        else if (cyc - last_at != div + 1) bad_half++;
        last_at = cyc;
        leading = (prev == cpol);
        capture = (leading != cpha);
        if (capture) begin
          got = {got[14:0], mosi};
          caps++;
          if (caps < n) miso = reply[n-1-caps];
        end
        edges++;
        prev = sclk;
      end
    end
    chk(bad_half == 0, "R3 half period length", bad_half, 0);
    chk(first_at == setup + div + 2, "R4 setup before first edge", first_at, setup + div + 2);
    chk(cyc - last_at == hold + 1, "R5 hold after last edge", cyc - last_at, hold + 1);
    chk(edges == 2 * n, "R6 edge count", edges, 2 * n);
    chk(sclk == cpol, "R6 sclk back at idle", sclk, cpol);
    chk((got & mask) == (data & mask), "R7 R8 bits on mosi", got & mask, data & mask);
    chk(done == 1'b1 && cmd_ready == 1'b1, "R10 done with ready", {done, cmd_ready}, 3);
    if (rw) exp_rd = reply & mask;
    chk(rd_data == exp_rd, "R11 rd_data", rd_data, exp_rd);
    chk(cs == ~act_hi, "R9 cs idle level", cs, ~act_hi);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R10 single pulse", done, 0);
      chk(cs == ~act_hi && cmd_ready, "R2 no extra transfer", cs, ~act_hi);
      chk(sclk == cpol, "R1 sclk idle", sclk, cpol);
    end
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk(cs == 1'b1 && sclk == 1'b0 && done == 1'b0, "R1 reset outputs", {cs, sclk, done}, 4);
    chk(rd_data == 16'h0 && cmd_ready == 1'b1, "R1 reset rd/ready", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1 && cs == 1'b1, "R1 idle after reset", {cmd_ready, cs}, 3);

    // Directed: four clock modes, minimal timing, 8-bit read
    xfer(16'h00A5, 16'h003C, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    xfer(16'h005A, 16'h00C3, 0, 1, 0, 0, 1, 0, 0, 0, 0);
    xfer(16'h0081, 16'h0011, 0, 1, 0, 1, 0, 0, 0, 0, 0);
    xfer(16'h007E, 16'h00E7, 0, 1, 0, 1, 1, 0, 0, 0, 0);
    // R7: all-ones dummy word, 16-bit read
    xfer(16'hFFFF, 16'hBEEF, 1, 1, 0, 0, 0, 1, 2, 1, 0);
    // R9: active-high chip select, longer delays
    xfer(16'h1234, 16'h8001, 1, 1, 1, 0, 1, 3, 5, 7, 0);
    // R11: write-only keeps previous rd_data
    xfer(16'hC0DE, 16'h5555, 1, 0, 1, 1, 0, 2, 1, 3, 0);
    // R2: command offered while busy is ignored
    xfer(16'h00F0, 16'h000F, 0, 1, 0, 0, 0, 1, 3, 2, 1);

    for (int k = 0; k < 40; k++) begin
      xfer(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom),
           int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
           int'($urandom_range(0, 15)), 1'($urandom));
    end
    finish_sim();
  end
endmodule